// File: doc/BRIEF.md
# Burst Multiplexed Address/Data Bus Master

This block drives one external chip-select region over a single 32-bit shared bus that carries the address first and the data after it. An internal requester hands it a read or write with a 26-bit word address, a 3-bit access-size code and a burst length. The block opens the region with its chip select, sends one address phase on the shared bus, then runs one data phase per word. Each data phase is lengthened by a programmable number of software wait cycles and by the external wait input.

During the address phase the shared bus carries the size code in its top three lines and the address in its low 26 lines. A separate address output carries the current word address in parallel. A read always has one turnaround cycle after the address phase, in which the master releases the shared bus. A write drives the write data in every data phase. The frame strobe stays low across the burst and goes high during the final word's data phase, so the device knows which transfer is the last.

Top module: `mpx_burst_master`

## Requirements
- R1: After a synchronous reset, including one applied in the middle of a burst, the block is idle from the next cycle. Idle means `cs_n`, `frame_n` and `bs_n` are high, `dq_oe` and `ack` are low, and `req_ready` is high.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. The next cycle is the address phase, in which `cs_n`, `frame_n` and `bs_n` are low and `dq_oe` is high. In that phase `dq_o` carries the size code in bits 31..29, zeros in bits 28..26 and the address in bits 25..0. `bs_n` is low in this cycle only.
- R3: A read (`req_write`=0) inserts exactly one turnaround cycle after the address phase, with `dq_oe` low, even when the software wait count is 0. A write has no turnaround.
- R4: Each data phase lasts at least W+1 cycles, where W is the value on `sw_wait` in the accepting cycle. Changes to `sw_wait` during the transfer have no effect.
- R5: Once the W software wait cycles of a data phase have passed, each cycle with `wait_n` low stretches that phase by one cycle. `wait_n` low during the software wait cycles has no effect.
- R6: `ack` is high for one cycle at the completion of each word. On reads, `rd_data` in that cycle equals `dq_i`. On writes, `dq_oe` is high throughout every data phase and `dq_o` equals `wr_data`.
- R7: The burst code `req_len` 0, 1, 2, 3 selects 1, 2, 4 or 8 words. The block returns to idle in the cycle after the last `ack`.
- R8: `cs_n` is low from the address phase through the last data phase. `frame_n` is low in every active cycle except the data phase of the last word, where it is high.
- R9: While `cs_n` is low, `ext_addr` equals the request address plus 4 times the index of the current word (0 for the address and turnaround phases), modulo 2^26.
- R10: While `cs_n` is low, `rdwr` is 1 for a read and 0 for a write.
- R11: `req_ready` is low while a transfer is in progress, and `req_valid` is ignored then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 26 | Start word address |
| req_size | input | 3 | Access-size code sent in the address phase |
| req_len | input | 2 | Burst code: words = 2^code |
| sw_wait | input | 4 | Software wait cycles per data phase |
| wr_data | input | 32 | Write data for the current word |
| ack | output | 1 | One pulse per completed word |
| rd_data | output | 32 | Read data, valid with ack |
| cs_n | output | 1 | Chip select, active low |
| frame_n | output | 1 | Frame strobe, active low, high on last word |
| bs_n | output | 1 | Bus-start strobe, active low |
| rdwr | output | 1 | 1 = read, 0 = write |
| wait_n | input | 1 | External wait, active low |
| ext_addr | output | 26 | Parallel word address |
| dq_o | output | 32 | Shared bus output value |
| dq_oe | output | 1 | Shared bus output enable |
| dq_i | input | 32 | Shared bus input value |

## Verification
The collision that matters is the expiry of the software wait count in the same cycle as a low `wait_n`. In that cycle the word must not complete; the hardware stretch takes over.

The bench holds `wait_n` low across the tail of the software wait window and past its end, so the input is already low on the expiry cycle. Its reference model counts the software cycles separately and expects `ack` only on the first cycle after expiry that sees `wait_n` high.

A second collision sits at a word boundary. The last word's completion and the drop of `frame_n` must agree, and the bench checks both against the burst length on every cycle.

// File: rtl/mpx_pkg.sv
package mpx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_TURN,
    PH_DATA
  } phase_e;

  // words in a burst for a length code: 2^code
  function automatic int unsigned burst_words(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // byte offset of word index within the burst
  function automatic int unsigned word_offset(input int unsigned idx);
    return idx * 4;
  endfunction

endpackage

// File: rtl/mpx_wait_ctr.sv
module mpx_wait_ctr #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              run,
  output logic              expired
);
  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (run && cnt != '0) begin
      cnt <= cnt - WAIT_W'(1);
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/mpx_seq.sv
module mpx_seq
  import mpx_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int SIZE_W = 3,
  parameter int WAIT_W = 4,
  parameter int LEN_W  = 2,
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [WAIT_W-1:0] sw_wait,
  input  logic              sw_expired,
  input  logic              wait_n,
  output phase_e            phase,
  output logic              write_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [SIZE_W-1:0] size_q,
  output logic [WAIT_W-1:0] wait_q,
  output logic [BEAT_W-1:0] beat,
  output logic              last_word,
  output logic              word_done,
  output logic              wait_load
);
  localparam logic [BEAT_W:0] ONE = 1;

  logic [LEN_W-1:0] len_q;
  logic [BEAT_W:0]  words_q;

  assign words_q   = (BEAT_W+1)'(burst_words(int'(len_q)));
  assign last_word = ({1'b0, beat} == (words_q - ONE));
  assign word_done = (phase == PH_DATA) && sw_expired && wait_n;
  assign wait_load = ((phase == PH_ADDR) && write_q) || (phase == PH_TURN) ||
                     (word_done && !last_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      write_q <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      wait_q  <= '0;
      len_q   <= '0;
      beat    <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            write_q <= req_write;
            addr_q  <= req_addr;
            size_q  <= req_size;
            wait_q  <= sw_wait;
            len_q   <= req_len;
            beat    <= '0;
            phase   <= PH_ADDR;
          end
        end
        PH_ADDR: phase <= write_q ? PH_DATA : PH_TURN;
        PH_TURN: phase <= PH_DATA;
        PH_DATA: begin
          if (word_done) begin
            if (last_word) phase <= PH_IDLE;
            else           beat  <= beat + BEAT_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mpx_bus_drive.sv
module mpx_bus_drive
  import mpx_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int SIZE_W = 3,
  parameter int DATA_W = 32,
  parameter int BEAT_W = 3
) (
  input  phase_e            phase,
  input  logic              write_q,
  input  logic              last_word,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [SIZE_W-1:0] size_q,
  input  logic [BEAT_W-1:0] beat,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cs_n,
  output logic              frame_n,
  output logic              bs_n,
  output logic              rdwr,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_o,
  output logic [ADDR_W-1:0] ext_addr
);
  localparam int SIZE_SHIFT = DATA_W - SIZE_W;

  logic [DATA_W-1:0] addr_word;

  assign addr_word = (DATA_W'(size_q) << SIZE_SHIFT) | DATA_W'(addr_q);

  always_comb begin
    cs_n    = (phase == PH_IDLE);
    bs_n    = (phase != PH_ADDR);
    frame_n = !((phase == PH_ADDR) || (phase == PH_TURN) ||
                ((phase == PH_DATA) && !last_word));
    rdwr    = (phase == PH_IDLE) ? 1'b1 : !write_q;
    dq_oe   = (phase == PH_ADDR) || ((phase == PH_DATA) && write_q);
    dq_o    = (phase == PH_ADDR) ? addr_word : wr_data;
  end

  assign ext_addr = addr_q + ADDR_W'(word_offset(int'(beat)));
endmodule

// File: rtl/mpx_burst_master.sv
module mpx_burst_master
  import mpx_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int SIZE_W = 3,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 4,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [WAIT_W-1:0] sw_wait,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              cs_n,
  output logic              frame_n,
  output logic              bs_n,
  output logic              rdwr,
  input  logic              wait_n,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_i
);
  localparam int MAX_WORDS = 1 << ((1 << LEN_W) - 1);
  localparam int BEAT_W    = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

  phase_e            phase;
  logic              write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SIZE_W-1:0] size_q;
  logic [WAIT_W-1:0] wait_q;
  logic [BEAT_W-1:0] beat;
  logic              last_word;
  logic              word_done;
  logic              wait_load;
  logic              sw_expired;

  mpx_seq #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .WAIT_W(WAIT_W),
    .LEN_W(LEN_W), .BEAT_W(BEAT_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_len(req_len), .sw_wait(sw_wait),
    .sw_expired(sw_expired), .wait_n(wait_n),
    .phase(phase), .write_q(write_q), .addr_q(addr_q), .size_q(size_q),
    .wait_q(wait_q), .beat(beat), .last_word(last_word),
    .word_done(word_done), .wait_load(wait_load)
  );

  mpx_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
    .clk(clk), .rst(rst),
    .load(wait_load), .load_val(wait_q),
    .run(phase == PH_DATA),
    .expired(sw_expired)
  );

  mpx_bus_drive #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W), .BEAT_W(BEAT_W)
  ) u_drive (
    .phase(phase), .write_q(write_q), .last_word(last_word),
    .addr_q(addr_q), .size_q(size_q), .beat(beat), .wr_data(wr_data),
    .cs_n(cs_n), .frame_n(frame_n), .bs_n(bs_n), .rdwr(rdwr),
    .dq_oe(dq_oe), .dq_o(dq_o), .ext_addr(ext_addr)
  );

  assign req_ready = (phase == PH_IDLE);
  assign ack       = word_done;
  assign rd_data   = dq_i;
endmodule

// File: rtl/mpx_burst_checker.sv
module mpx_burst_checker (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic cs_n,
  input logic frame_n,
  input logic bs_n,
  input logic rdwr,
  input logic dq_oe,
  input logic ack,
  input logic last_word
);
  p_accept_addr_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !bs_n && !cs_n && !frame_n && dq_oe);

  p_bs_single_r2: assert property (@(posedge clk) disable iff (rst)
    !bs_n |=> bs_n);

  p_read_turn_r3: assert property (@(posedge clk) disable iff (rst)
    !bs_n && rdwr |=> !dq_oe && !ack && !cs_n);

  p_write_no_turn_r3: assert property (@(posedge clk) disable iff (rst)
    !bs_n && !rdwr |=> dq_oe);

  p_ack_active_r6: assert property (@(posedge clk) disable iff (rst)
    ack |-> !cs_n && !req_ready);

  p_end_idle_r7: assert property (@(posedge clk) disable iff (rst)
    ack && frame_n |=> cs_n && req_ready);

  p_continue_r7: assert property (@(posedge clk) disable iff (rst)
    ack && !frame_n |=> !cs_n);

  p_last_frame_r8: assert property (@(posedge clk) disable iff (rst)
    ack && last_word |-> frame_n);

  p_frame_in_cs_r8: assert property (@(posedge clk) disable iff (rst)
    !frame_n |-> !cs_n);

  p_ready_idle_r11: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> cs_n && frame_n && bs_n && !dq_oe && !ack);
endmodule

bind mpx_burst_master mpx_burst_checker u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .cs_n(cs_n), .frame_n(frame_n), .bs_n(bs_n), .rdwr(rdwr),
  .dq_oe(dq_oe), .ack(ack), .last_word(last_word)
);

// File: tb/mpx_burst_master_test.sv
module mpx_burst_master_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit          v;
    bit          w;
    logic [25:0] a;
    logic [2:0]  sz;
    logic [1:0]  ln;
    logic [3:0]  sw;
    logic [31:0] wd;
    bit          wt;
    logic [31:0] di;
    bit          e_rdy, e_cs, e_fr, e_bs, e_rw, e_oe, e_ack;
    logic [31:0] e_dq;
    logic [25:0] e_ad;
  } cyc_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [25:0] req_addr = '0;
  logic [2:0]  req_size = '0;
  logic [1:0]  req_len = '0;
  logic [3:0]  sw_wait = '0;
  logic [31:0] wr_data = '0, dq_i = '0;
  logic        wait_n = 1'b1;
  logic        req_ready, ack, cs_n, frame_n, bs_n, rdwr, dq_oe;
  logic [31:0] rd_data, dq_o;
  logic [25:0] ext_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  cyc_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mpx_burst_master uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_len(req_len), .sw_wait(sw_wait), .wr_data(wr_data), .ack(ack),
    .rd_data(rd_data), .cs_n(cs_n), .frame_n(frame_n), .bs_n(bs_n),
    .rdwr(rdwr), .wait_n(wait_n), .ext_addr(ext_addr), .dq_o(dq_o),
    .dq_oe(dq_oe), .dq_i(dq_i)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic cyc_t idle_cyc();
    cyc_t c;
    c.v = 0; c.w = 0; c.a = '0; c.sz = '0; c.ln = '0; c.sw = '0;
    c.wd = '0; c.wt = 1; c.di = '0;
    c.e_rdy = 1; c.e_cs = 1; c.e_fr = 1; c.e_bs = 1; c.e_rw = 1;
    c.e_oe = 0; c.e_ack = 0; c.e_dq = '0; c.e_ad = '0;
    return c;
  endfunction

  // busy cycle: junk request on the internal port (R11, R4 ignore)
  function automatic cyc_t busy_cyc(input bit wr, input logic [3:0] sw);
    cyc_t c = idle_cyc();
    c.v = 1; c.w = !wr; c.a = 26'h2AAAAAA; c.sz = 3'b111; c.ln = 2'd3;
    c.sw = ~sw; c.e_rdy = 0; c.e_cs = 0; c.e_rw = !wr;
    return c;
  endfunction

  task automatic push_idle(input int n);
    for (int i = 0; i < n; i++) q.push_back(idle_cyc());
  endtask

  task automatic push_txn(input bit wr, input logic [25:0] base,
                          input logic [2:0] sz, input logic [1:0] ln,
                          input int sw, input int seed);
    cyc_t c;
    int nwords = 1;
    for (int k = 0; k < ln; k++) nwords = nwords * 2;
    c = idle_cyc();
    c.v = 1; c.w = wr; c.a = base; c.sz = sz; c.ln = ln; c.sw = 4'(sw);
    q.push_back(c);
    c = busy_cyc(wr, 4'(sw));
    c.e_bs = 0; c.e_fr = 0; c.e_oe = 1; c.e_ad = base;
    c.e_dq = {sz, 3'b000, base};
    q.push_back(c);
    if (!wr) begin
      c = busy_cyc(wr, 4'(sw));
      c.e_fr = 0; c.e_ad = base;
      q.push_back(c);
    end
    for (int b = 0; b < nwords; b++) begin
      int hw = (b * 2 + seed) % 3;
      int early = (b + seed) % 3;
      logic [25:0] wa = base + 26'(4 * b);
      if (early > sw) early = sw;
      for (int i = 0; i <= sw + hw; i++) begin
        c = busy_cyc(wr, 4'(sw));
        c.wt = !((i >= sw - early) && (i < sw + hw));
        c.e_fr = (b == nwords - 1);
        c.e_oe = wr;
        c.wd = 32'hD0000000 | (32'(seed) << 8) | 32'(b);
        c.di = 32'hA5000000 | (32'(seed) << 8) | 32'(b);
        c.e_dq = c.wd;
        c.e_ad = wa;
        c.e_ack = (i == sw + hw);
        q.push_back(c);
      end
    end
  endtask

  task automatic run_queue();
    while (q.size() > 0) begin
      cyc_t c = q.pop_front();
      req_valid = c.v; req_write = c.w; req_addr = c.a; req_size = c.sz;
      req_len = c.ln; sw_wait = c.sw; wr_data = c.wd; wait_n = c.wt; dq_i = c.di;
      #1;
      chk("R11", "req_ready", 32'(req_ready), 32'(c.e_rdy));
      chk("R8",  "cs_n",      32'(cs_n),      32'(c.e_cs));
      chk("R8",  "frame_n",   32'(frame_n),   32'(c.e_fr));
      chk("R2",  "bs_n",      32'(bs_n),      32'(c.e_bs));
      chk("R3",  "dq_oe",     32'(dq_oe),     32'(c.e_oe));
      chk("R4",  "ack",       32'(ack),       32'(c.e_ack));
      if (!c.e_cs) begin
        chk("R10", "rdwr",     32'(rdwr),     32'(c.e_rw));
        chk("R9",  "ext_addr", 32'(ext_addr), 32'(c.e_ad));
      end
      if (c.e_oe) chk("R6", "dq_o", dq_o, c.e_dq);
      if (c.e_ack && c.e_rw) chk("R6", "rd_data", rd_data, c.di);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset cs_n", 32'(cs_n), 32'd1);
    chk("R1", "reset frame_n", 32'(frame_n), 32'd1);
    chk("R1", "reset bs_n", 32'(bs_n), 32'd1);
    chk("R1", "reset dq_oe", 32'(dq_oe), 32'd0);
    chk("R1", "reset req_ready", 32'(req_ready), 32'd1);
    rst = 1'b0;
    @(negedge clk);
    push_idle(2);
    push_txn(1'b1, 26'h0001234, 3'd2, 2'd0, 0, 0);   // R2 single write
    push_txn(1'b0, 26'h0000100, 3'd1, 2'd0, 0, 1);   // R3 read, zero sw wait
    push_txn(1'b1, 26'h0123400, 3'd4, 2'd2, 2, 2);   // R5 sw 2 with hw overlap
    push_idle(1);
    push_txn(1'b0, 26'h0ABCDE0, 3'd3, 2'd3, 1, 0);   // R7 eight words
    push_txn(1'b0, 26'h3FFFFFC, 3'd2, 2'd1, 3, 1);   // R9 address wrap
    push_txn(1'b1, 26'h0000040, 3'd5, 2'd3, 0, 2);   // R5 zero sw, hw only
    push_idle(1);
    run_queue();
    // R1: reset in the middle of a burst
    push_txn(1'b1, 26'h0000800, 3'd2, 2'd2, 5, 0);
    for (int i = 0; i < 4; i++) void'(q.pop_back());
    run_queue();
    rst = 1'b1; req_valid = 1'b0;
    @(negedge clk);
    #1;
    chk("R1", "mid-burst reset cs_n", 32'(cs_n), 32'd1);
    chk("R1", "mid-burst reset frame_n", 32'(frame_n), 32'd1);
    chk("R1", "mid-burst reset req_ready", 32'(req_ready), 32'd1);
    chk("R1", "mid-burst reset dq_oe", 32'(dq_oe), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    push_txn(1'b1, 26'h0000900, 3'd2, 2'd1, 1, 1);
    push_idle(2);
    run_queue();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule